// File: doc/BRIEF.md
# Serial Audio Transmitter with Daisy-Chain TDM

This block turns a pair of signed 24-bit audio samples into a one-bit serial stream with a companion framing pin. An external clock generator supplies a one-cycle strobe, `bit_en`, for each falling edge of the bit clock. The block changes its outputs only on those strobes, so a receiver can sample them on the rising edge. Four framings are available. Three are two-channel formats: MSB-first left-aligned, MSB-first with the MSB delayed by one bit, and LSB-aligned at the end of the slot. The fourth is a long multi-slot frame that several transmitters can share on one processor port.

The output word length can be 24, 20, 18 or 16 bits. For any length shorter than 24, a pseudo-random dither worth one output LSB is added to the sample. The sum is clamped at the signed full-scale limits and then cut to the chosen length. In the multi-slot mode the device places its own two words at the head of the frame. For every later bit position it forwards the value on its chain input, so an upstream device's stream rides behind its own. Format, word length and both samples are sampled only when a new frame begins.

Top module: `stx_serializer`

## Requirements
- R1: While `rst` is high and after its release, `sdata` and `lrclk_fs` are 0. The first `bit_en` after reset starts a new frame, with bit position 0.
- R2: `sdata` and `lrclk_fs` change only in cycles where `bit_en` is high.
- R3: Format code `fmt_sel`=0 (left-aligned) uses a 64-bit frame made of two 32-bit slots, left slot first. `lrclk_fs` is 1 during the left slot and 0 during the right slot. The word MSB is at slot bit 0, followed by the rest MSB-first, and the remaining slot bits are 0.
- R4: Format code 1 (delayed) uses the same frame as R3, but `lrclk_fs` is 0 for the left slot and 1 for the right slot. The word MSB sits at slot bit 1, and all other slot bits are 0.
- R5: Format code 2 (LSB-aligned) uses the framing pin polarity of R3. The W-bit word occupies slot bits 32-W through 31, so its LSB lands on the last bit of the slot.
- R6: Format code 3 (multi-slot) uses a frame of TDM_SLOTS×32 bits (256 by default). `lrclk_fs` is 1 only at bit 0 of the frame. Slot 0 carries the left word and slot 1 the right word, laid out as in R3. From bit 64 onward, `sdata` takes the `chain_in` value sampled on the same `bit_en`.
- R7: `wlen_sel` chooses the word length W: 0→16, 1→18, 2→20, 3→24. With W=24 the sample is sent unchanged.
- R8: For W<24, let k=24−W. The dither is the low k bits of a dither byte, minus 2^(k−1). The left channel takes its byte from state bits [7:0] and the right channel from bits [23:16]. The state comes from a 32-bit shift register seeded to 0xACE12468 at reset. It steps once per frame start as {s[30:0], s[31]^s[21]^s[1]^s[0]}, and the state before the step is the one used. The sent word is bits [23:k] of the clamped sum.
- R9: The sample-plus-dither sum clamps at 0x7FFFFF and at 0x800000 instead of wrapping. A full-scale input therefore yields the W-bit full-scale code.
- R10: Format, word length and both samples are captured only at the `bit_en` that starts a frame. Changes to them in the middle of a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per falling bit-clock edge |
| fmt_sel | input | 2 | Framing code (0 left-aligned, 1 delayed, 2 LSB-aligned, 3 multi-slot) |
| wlen_sel | input | 2 | Word length code (0:16, 1:18, 2:20, 3:24) |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| chain_in | input | 1 | Serial data from the upstream device in the chain |
| sdata | output | 1 | Serial data out |
| lrclk_fs | output | 1 | Channel clock, or frame sync in multi-slot mode |

## Verification
The critical coincidence is the frame-start strobe. In that one `bit_en` the block takes new format, word length, samples and a fresh dither draw, and it also emits bit 0 of the new frame, which already uses all of them. The bench provokes this by changing format and samples at every frame boundary and again in the middle of each frame. A scoreboard model decides, strobe by strobe, which values must govern each bit. In multi-slot mode, the change from the device's own right word to forwarded chain bits, and the wrap from the last forwarded bit back to its own left word, are both checked bit by bit against random chain data.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int SLOT_BITS = 32;
    localparam int SLOT_LSB = $clog2(SLOT_BITS);
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'd0,
        FMT_DLY = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_TDM = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        WL16 = 2'd0,
        WL18 = 2'd1,
        WL20 = 2'd2,
        WL24 = 2'd3
    } wlen_e;

    typedef struct packed {
        fmt_e  fmt;
        wlen_e wl;
    } cfg_t;

    function automatic logic [4:0] wl_bits(wlen_e w);
        case (w)
            WL16:    return 5'd16;
            WL18:    return 5'd18;
            WL20:    return 5'd20;
            default: return 5'd24;
        endcase
    endfunction

    function automatic logic [31:0] lfsr_next(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // right-aligned W-bit positive full scale
    function automatic logic [SAMPLE_W-1:0] max_pos(wlen_e w);
        return SAMPLE_W'((25'd1 << (wl_bits(w) - 5'd1)) - 25'd1);
    endfunction

    // bit at slot position p of a right-aligned word of width w
    function automatic logic pick_bit(fmt_e f, logic [4:0] w, logic [SLOT_LSB-1:0] p,
                                      logic [SAMPLE_W-1:0] word);
        int wi;
        int pi;
        logic b;
        wi = int'(w);
        pi = int'(p);
        b  = 1'b0;
        case (f)
            FMT_DLY: if (pi >= 1 && pi <= wi) b = word[wi - pi];
            FMT_RJ:  if (pi >= SLOT_BITS - wi) b = word[SLOT_BITS - 1 - pi];
            default: if (pi < wi) b = word[wi - 1 - pi];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/stx_lfsr.sv
module stx_lfsr #(
    parameter logic [31:0] SEED = 32'hACE1_2468
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    output logic [31:0] state
);
    import stx_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)       state <= SEED;
        else if (step) state <= lfsr_next(state);
    end

    // R8: a maximal sequence never reaches the all-zero lock-up state
    p_lfsr_live_r8: assert property (@(posedge clk) disable iff (rst) state != 32'd0);

endmodule

// File: rtl/stx_requant.sv
module stx_requant
    import stx_pkg::*;
(
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [4:0]          wbits,
    input  logic [7:0]          dith,
    output logic [SAMPLE_W-1:0] word
);
    localparam int SUM_W = SAMPLE_W + 2;

    logic [4:0]              k;
    logic [7:0]              mask;
    logic [SUM_W-1:0]        half;
    logic signed [SUM_W-1:0] sx, dv, sum;
    logic [SAMPLE_W-1:0]     sat, shifted, wmask;

    always_comb begin
        k     = 5'(SAMPLE_W) - wbits;
        mask  = 8'((9'd1 << k) - 9'd1);
        half  = (k == 5'd0) ? '0 : (SUM_W'(1) << (k - 5'd1));
        sx    = {{2{sample[SAMPLE_W-1]}}, sample};
        dv    = $signed({18'd0, dith & mask}) - $signed(half);
        sum   = sx + dv;
        if (sum > $signed(SUM_W'(24'h7FFFFF)))
            sat = 24'h7FFFFF;
        else if (sum < -$signed(SUM_W'(24'h800000)))
            sat = 24'h800000;
        else
            sat = sum[SAMPLE_W-1:0];
        shifted = SAMPLE_W'($signed(sat) >>> k);
        wmask   = SAMPLE_W'((25'd1 << wbits) - 25'd1);
        word    = shifted & wmask;
    end

endmodule

// File: rtl/stx_serializer.sv
module stx_serializer
    import stx_pkg::*;
#(
    parameter int          TDM_SLOTS = 8,
    parameter logic [31:0] LFSR_SEED = 32'hACE1_2468
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_en,
    input  logic [1:0]  fmt_sel,
    input  logic [1:0]  wlen_sel,
    input  logic [23:0] left_in,
    input  logic [23:0] right_in,
    input  logic        chain_in,
    output logic        sdata,
    output logic        lrclk_fs
);
    localparam int FRAME_TDM = TDM_SLOTS * SLOT_BITS;
    localparam int FRAME_ST  = NUM_CH * SLOT_BITS;
    localparam int CNT_W     = $clog2(FRAME_TDM);

    logic [CNT_W-1:0]    cnt_q, cnt_n, last;
    cfg_t                cfg_q, cfg_n;
    logic [SAMPLE_W-1:0] word_q [NUM_CH];
    logic [SAMPLE_W-1:0] word_n [NUM_CH];
    logic [SAMPLE_W-1:0] smp    [NUM_CH];
    logic [SAMPLE_W-1:0] quant  [NUM_CH];
    logic [31:0]         lfsr_q;
    logic                wrap;
    logic [4:0]          wbits_in, wbits_n;
    logic                ch_n, own_n, sd_n, fr_n;

    assign smp[0]   = left_in;
    assign smp[1]   = right_in;
    assign wbits_in = wl_bits(wlen_e'(wlen_sel));

    stx_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .step  (bit_en && wrap),
        .state (lfsr_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        stx_requant u_rq (
            .sample (smp[c]),
            .wbits  (wbits_in),
            .dith   (lfsr_q[16*c +: 8]),
            .word   (quant[c])
        );
    end

    always_comb begin
        last  = (cfg_q.fmt == FMT_TDM) ? CNT_W'(FRAME_TDM - 1) : CNT_W'(FRAME_ST - 1);
        wrap  = (cnt_q == last);
        cnt_n = wrap ? '0 : cnt_q + CNT_W'(1);
        cfg_n = wrap ? cfg_t'{fmt: fmt_e'(fmt_sel), wl: wlen_e'(wlen_sel)} : cfg_q;
        for (int c = 0; c < NUM_CH; c++)
            word_n[c] = wrap ? quant[c] : word_q[c];
        wbits_n = wl_bits(cfg_n.wl);
        ch_n    = cnt_n[SLOT_LSB];
        own_n   = (cnt_n < CNT_W'(FRAME_ST));
        if (cfg_n.fmt == FMT_TDM && !own_n)
            sd_n = chain_in;
        else
            sd_n = pick_bit(cfg_n.fmt, wbits_n, cnt_n[SLOT_LSB-1:0],
                            ch_n ? word_n[1] : word_n[0]);
        case (cfg_n.fmt)
            FMT_TDM: fr_n = (cnt_n == '0);
            FMT_DLY: fr_n = ch_n || !own_n;
            default: fr_n = own_n && !ch_n;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= CNT_W'(FRAME_ST - 1);
            cfg_q    <= cfg_t'{fmt: FMT_LJ, wl: WL24};
            sdata    <= 1'b0;
            lrclk_fs <= 1'b0;
            for (int c = 0; c < NUM_CH; c++) word_q[c] <= '0;
        end else if (bit_en) begin
            cnt_q    <= cnt_n;
            cfg_q    <= cfg_n;
            sdata    <= sd_n;
            lrclk_fs <= fr_n;
            for (int c = 0; c < NUM_CH; c++) word_q[c] <= word_n[c];
        end
    end

    // R2: outputs hold between bit strobes
    p_hold_between_bits_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(sdata) && $stable(lrclk_fs)));

    // R6: frame sync lasts exactly one bit in multi-slot mode
    p_fsync_one_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_en && lrclk_fs && cfg_q.fmt == FMT_TDM) |=> !lrclk_fs);

    // R7: 24-bit words pass through unchanged
    p_pass24_r7: assert property (@(posedge clk) disable iff (rst)
        (bit_en && wrap && wlen_sel == 2'd3) |=> (word_q[0] == $past(left_in)));

    // R9: positive full scale clamps to the W-bit maximum
    p_sat_pos_r9: assert property (@(posedge clk) disable iff (rst)
        (bit_en && wrap && left_in == 24'h7FFFFF) |=> (word_q[0] == max_pos(cfg_q.wl)));

    // R10: captured configuration holds within a frame
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !wrap) |=> $stable(cfg_q));

endmodule

// File: tb/stx_serializer_tb.sv
module stx_serializer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_en;
    logic [1:0]  fmt_sel, wlen_sel;
    logic [23:0] left_in, right_in;
    logic        chain_in;
    logic        sdata, lrclk_fs;

    always #4 clk = ~clk;

    stx_serializer u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
        .left_in(left_in), .right_in(right_in), .chain_in(chain_in),
        .sdata(sdata), .lrclk_fs(lrclk_fs)
    );

    typedef struct {
        logic  sd;
        logic  fr;
        int    pos;
        string tag;
    } exp_t;

    exp_t q_exp[$];
    int   n_chk = 0;
    int   n_fail = 0;
    logic en_d = 1'b0;
    logic started = 1'b0;
    logic prev_sd, prev_fr;

    // reference model state
    int          m_cnt;
    int          m_fmt, m_w;
    logic [23:0] m_l, m_r;
    logic [31:0] m_s;
    logic        m_sat;

    function automatic int wl_of(logic [1:0] c);
        return (c == 2'd3) ? 24 : 16 + 2 * int'(c);
    endfunction

    function automatic logic [23:0] quant(logic [23:0] x, int w, logic [7:0] d8);
        longint s;
        int k;
        k = 24 - w;
        s = longint'($signed(x));
        if (k > 0) s = s + longint'(int'(d8) % (1 << k)) - longint'(1 << (k - 1));
        if (s > 64'sd8388607) s = 64'sd8388607;
        if (s < -64'sd8388608) s = -64'sd8388608;
        s = s >>> k;
        return 24'(s & ((64'sd1 <<< w) - 64'sd1));
    endfunction

    function automatic logic exp_bit(int f, int w, int p, logic [23:0] wd);
        int st;
        st = (f == 1) ? 1 : (f == 2) ? 32 - w : 0;
        if (p >= st && p < st + w) return wd[w - 1 - (p - st)];
        return 1'b0;
    endfunction

    task automatic tick(input logic cb);
        exp_t e;
        int   last;
        int   p;
        @(negedge clk);
        chain_in = cb;
        bit_en   = 1'b1;
        last = (m_fmt == 3) ? 255 : 63;
        if (m_cnt == last) begin
            m_cnt = 0;
            m_fmt = int'(fmt_sel);
            m_w   = wl_of(wlen_sel);
            m_sat = (left_in == 24'h7FFFFF) || (right_in == 24'h800000);
            m_l   = quant(left_in, m_w, m_s[7:0]);
            m_r   = quant(right_in, m_w, m_s[23:16]);
            m_s   = {m_s[30:0], m_s[31] ^ m_s[21] ^ m_s[1] ^ m_s[0]};
        end else begin
            m_cnt++;
        end
        p = m_cnt % 32;
        if (m_fmt == 3 && m_cnt >= 64) e.sd = cb;
        else e.sd = exp_bit(m_fmt, m_w, p, (m_cnt >= 32) ? m_r : m_l);
        case (m_fmt)
            3:       e.fr = (m_cnt == 0);
            1:       e.fr = (m_cnt >= 32);
            default: e.fr = (m_cnt < 32);
        endcase
        e.pos = m_cnt;
        case (m_fmt)
            0: e.tag = "R3";
            1: e.tag = "R4";
            2: e.tag = "R5";
            default: e.tag = "R6";
        endcase
        e.tag = {e.tag, (m_w == 24) ? "/R7" : "/R8", m_sat ? "/R9" : "", "/R10"};
        q_exp.push_back(e);
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    always @(posedge clk) en_d <= bit_en;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (started) begin
            if (en_d) begin
                if (q_exp.size() > 0) begin
                    exp_t e;
                    e = q_exp.pop_front();
                    n_chk++;
                    if (sdata !== e.sd || lrclk_fs !== e.fr) begin
                        n_fail++;
                        $display("FAIL %s: pos %0d sdata=%b lrclk_fs=%b expected %b %b",
                                 e.tag, e.pos, sdata, lrclk_fs, e.sd, e.fr);
                    end
                end
            end else begin
                n_chk++;  // R2: no change without a strobe
                if (sdata !== prev_sd || lrclk_fs !== prev_fr) begin
                    n_fail++;
                    $display("FAIL R2: outputs moved without bit_en, got %b %b expected %b %b",
                             sdata, lrclk_fs, prev_sd, prev_fr);
                end
            end
            prev_sd = sdata;
            prev_fr = lrclk_fs;
        end
    end

    task automatic run_frames(input logic [1:0] f, input logic [1:0] wl, input int n);
        int len;
        len = (f == 2'd3) ? 256 : 64;
        for (int fr = 0; fr < n; fr++) begin
            fmt_sel  = f;
            wlen_sel = wl;
            if (fr == 0) begin
                left_in  = 24'h7FFFFF;
                right_in = 24'h800000;
            end else begin
                left_in  = 24'($urandom());
                right_in = 24'($urandom());
            end
            for (int b = 0; b < len; b++) begin
                tick(1'($urandom() % 2));
                if (b == 5) begin  // mid-frame disturbance, R10
                    fmt_sel  = ~f;
                    wlen_sel = ~wl;
                    left_in  = 24'($urandom());
                    right_in = 24'($urandom());
                end
            end
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; bit_en = 1'b0; chain_in = 1'b0;
        fmt_sel = 2'd0; wlen_sel = 2'd3; left_in = '0; right_in = '0;
        m_cnt = 63; m_fmt = 0; m_w = 24; m_l = '0; m_r = '0;
        m_s = 32'hACE1_2468; m_sat = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;  // R1 during reset
        if (sdata !== 1'b0 || lrclk_fs !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: in reset sdata=%b lrclk_fs=%b expected 0 0", sdata, lrclk_fs);
        end
        rst = 1'b0;
        @(negedge clk);
        n_chk++;  // R1 after release
        if (sdata !== 1'b0 || lrclk_fs !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: after reset sdata=%b lrclk_fs=%b expected 0 0", sdata, lrclk_fs);
        end
        prev_sd = sdata;
        prev_fr = lrclk_fs;
        started = 1'b1;

        run_frames(2'd0, 2'd3, 2);  // R3, R7
        run_frames(2'd1, 2'd3, 2);  // R4
        run_frames(2'd2, 2'd3, 2);  // R5
        run_frames(2'd0, 2'd0, 2);  // R8, R9 at 16 bits
        run_frames(2'd1, 2'd1, 2);  // R8 at 18 bits
        run_frames(2'd2, 2'd2, 2);  // R5, R8 at 20 bits
        run_frames(2'd2, 2'd0, 2);  // R5, R9 at 16 bits
        run_frames(2'd3, 2'd3, 2);  // R6
        run_frames(2'd3, 2'd2, 1);  // R6, R8
        run_frames(2'd0, 2'd1, 1);  // back to stereo after multi-slot
        repeat (4) @(negedge clk);
        if (q_exp.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d bits never observed, expected 0", q_exp.size());
        end
        finish_run();
    end

endmodule